// File: doc/BRIEF.md
# Triggered Timer Counter Core

A modulo counter for timing and PWM base generation. It is driven by a power-of-two prescaler and can count either on every system clock or on rising edges of a separate, asynchronous count clock. The count runs from zero up to a programmable modulo value. It then either wraps back to zero or reverses and counts down to zero again. Each completed period raises a sticky overflow flag. An interrupt line is derived from that flag.

A trigger input, with selectable active level, controls the counter in three ways. It can hold off counting until the trigger is seen. It can restart the counter after an overflow that stopped it. It can force the count back to zero. A pause request, when enabled by configuration, freezes the counter and masks trigger events. This lets the block be halted together with the rest of the system. The trigger input is expected to be synchronous to `clk`. The count clock is synchronised inside the block.

All configuration arrives as static inputs, so the block sits behind whatever register file the chip provides.

Top module: `trig_timer`

## Requirements
- R1: The prescale code p (0..7) makes the counter advance once per 2^p source events. The first advance comes 2^p source events after the counter starts running.
- R2: Clock mode 2'b01 uses every `clk` edge as a source event. Modes 2'b00 and 2'b11 stop all counting and keep the count at its value.
- R3: With `cfg_updown` = 0, each advance adds one. An advance taken at a count at or above `cfg_modulo` loads zero instead and signals an overflow. A modulo of zero therefore overflows on every advance.
- R4: With `cfg_updown` = 1, the count climbs to `cfg_modulo` and then falls back. The advance that brings it back to zero signals an overflow, so the period is 2*modulo advances. A modulo of zero holds the count at zero and overflows on every advance.
- R5: Clock mode 2'b10 takes each rising edge of `ext_clk` as a source event. The edge passes a two-flop synchroniser and an edge detector, so the count moves on the third `clk` edge after `ext_clk` rises.
- R6: With `cfg_start_trig` = 1, an enabled counter holds at its value until an active trigger edge arrives. The advances begin on the clock after that edge.
- R7: With `cfg_stop_ovf` = 1, the counter halts at zero after an overflow. It halts for good while `cfg_start_trig` = 0. With `cfg_start_trig` = 1 it re-arms and waits for the next trigger edge.
- R8: With `cfg_reload_trig` = 1, an active trigger edge loads zero and sets the direction to up. This takes priority over an advance in the same cycle.
- R9: `cfg_trig_pol` = 0 makes a rising edge of `trig_in` the active edge. `cfg_trig_pol` = 1 makes a falling edge the active one. The opposite transition has no effect.
- R10: While `pause_req` and `cfg_pause_en` are both 1, the count and prescaler hold and trigger edges are dropped. With `cfg_pause_en` = 0, `pause_req` is ignored.
- R11: `ovf_flag` sets on the clock of an overflow and stays set until an `ovf_clr` pulse clears it. An overflow in the same cycle as `ovf_clr` leaves the flag set.
- R12: `ovf_irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R13: Asserting `rst_n` low immediately forces the count to zero and clears the flag and interrupt. Release is synchronised to `clk` over two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| trig_in | input | 1 | Trigger input, synchronous to clk |
| pause_req | input | 1 | System pause request |
| cfg_mode | input | 2 | Clock mode: 00 off, 01 system clock, 10 external clock, 11 off |
| cfg_psc | input | PSC_W | Prescale code, divide by 2^code |
| cfg_updown | input | 1 | 0 up-only, 1 up-down |
| cfg_modulo | input | W | Terminal count value |
| cfg_trig_pol | input | 1 | 0 active high, 1 active low trigger |
| cfg_start_trig | input | 1 | Wait for trigger before counting |
| cfg_stop_ovf | input | 1 | Halt after overflow |
| cfg_reload_trig | input | 1 | Trigger edge reloads zero |
| cfg_pause_en | input | 1 | Honour pause_req |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | W | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Flag setting and flag clearing can land on the same edge. The bench counts the counter up to one advance before its wrap, then holds `ovf_clr` high across the wrap edge. The flag must read 1 afterwards, and a clear on the next edge, with no overflow, must read 0. A trigger reload can also meet an ordinary advance. In up-down mode this is judged by the count climbing again from zero on the clocks after the reload, which shows the direction was forced up.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HALT  = 2'd3
  } tt_state_e;

  localparam logic [1:0] CM_OFF  = 2'b00;
  localparam logic [1:0] CM_SYS  = 2'b01;
  localparam logic [1:0] CM_EXT  = 2'b10;
  localparam logic [1:0] CM_RSVD = 2'b11;
endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic [1:0]       mode,
  input  logic [PSC_W-1:0] psc,
  input  logic             hold,
  input  logic             clr,
  output logic             tick
);
  import tt_pkg::*;
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic             ext_s1_q, ext_s2_q, ext_s3_q;
  logic             ext_rise, src_pulse;
  logic [DIV_W-1:0] div_q, div_d, psc_mask;

  // two-flop synchroniser plus an edge-detect stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      ext_s3_q <= 1'b0;
    end else begin
      ext_s1_q <= ext_clk;
      ext_s2_q <= ext_s1_q;
      ext_s3_q <= ext_s2_q;
    end
  end

  assign ext_rise = ext_s2_q & ~ext_s3_q;

  always_comb begin
    src_pulse = (mode == CM_SYS) | ((mode == CM_EXT) & ext_rise);
    psc_mask  = ~({DIV_W{1'b1}} << psc);
    tick      = src_pulse & ~hold & ~clr & ((div_q & psc_mask) == psc_mask);
    if (clr)                    div_d = '0;
    else if (src_pulse && !hold) div_d = div_q + 1'b1;
    else                        div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tt_trig_edge.sv
module tt_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic pol,
  input  logic ignore,
  output logic rise
);
  logic act, act_q;

  assign act  = trig_in ^ pol;
  assign rise = act & ~act_q & ~ignore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end
endmodule

// File: rtl/tt_core.sv
module tt_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         updown,
  input  logic [W-1:0] modulo,
  input  logic         start_trig,
  input  logic         stop_ovf,
  input  logic         reload_trig,
  input  logic         pause,
  input  logic         tick,
  input  logic         trig_rise,
  output logic [W-1:0] count,
  output logic         running,
  output logic         ovf_evt
);
  import tt_pkg::*;

  tt_state_e    st_q, st_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;
  logic         wrap;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (!en) begin
      st_d = ST_OFF;
    end else if (!pause) begin
      case (st_q)
        ST_OFF:   st_d = (!start_trig || trig_rise) ? ST_RUN : ST_ARMED;
        ST_ARMED: if (trig_rise) st_d = ST_RUN;
        default:  st_d = st_q;
      endcase
      if (reload_trig && trig_rise) begin
        cnt_d = '0;
        dir_d = 1'b0;
      end else if (st_q == ST_RUN && tick) begin
        if (!updown) begin
          dir_d = 1'b0;
          if (cnt_q >= modulo) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (!dir_q) begin
          if (cnt_q < modulo) begin
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == '0) begin
            wrap = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == W'(1)) wrap  = 1'b1;
            else                dir_d = 1'b1;
          end
        end else begin
          if (cnt_q <= W'(1)) begin
            cnt_d = '0;
            dir_d = 1'b0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        if (wrap && stop_ovf) st_d = start_trig ? ST_ARMED : ST_HALT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count   = cnt_q;
  assign running = (st_q == ST_RUN);
  assign ovf_evt = wrap;
endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
  parameter int W     = 8,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             trig_in,
  input  logic             pause_req,
  input  logic [1:0]       cfg_mode,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic             cfg_updown,
  input  logic [W-1:0]     cfg_modulo,
  input  logic             cfg_trig_pol,
  input  logic             cfg_start_trig,
  input  logic             cfg_stop_ovf,
  input  logic             cfg_reload_trig,
  input  logic             cfg_pause_en,
  input  logic             ovf_ie,
  input  logic             ovf_clr,
  output logic [W-1:0]     count,
  output logic             ovf_flag,
  output logic             ovf_irq
);
  import tt_pkg::*;

  logic rs1_q, rs2_q;
  logic en, pause, tick, trig_rise, running, ovf_evt;
  logic flag_q, flag_d;

  // reset: asserted asynchronously, released on the second clk edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign en    = (cfg_mode == CM_SYS) | (cfg_mode == CM_EXT);
  assign pause = pause_req & cfg_pause_en;

  tt_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rs2_q),
    .ext_clk (ext_clk),
    .mode    (cfg_mode),
    .psc     (cfg_psc),
    .hold    (pause),
    .clr     (~running),
    .tick    (tick)
  );

  tt_trig_edge u_trig (
    .clk     (clk),
    .rst_n   (rs2_q),
    .trig_in (trig_in),
    .pol     (cfg_trig_pol),
    .ignore  (pause),
    .rise    (trig_rise)
  );

  tt_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rs2_q),
    .en          (en),
    .updown      (cfg_updown),
    .modulo      (cfg_modulo),
    .start_trig  (cfg_start_trig),
    .stop_ovf    (cfg_stop_ovf),
    .reload_trig (cfg_reload_trig),
    .pause       (pause),
    .tick        (tick),
    .trig_rise   (trig_rise),
    .count       (count),
    .running     (running),
    .ovf_evt     (ovf_evt)
  );

  // set beats clear when both land in one cycle
  always_comb begin
    if (ovf_evt)      flag_d = 1'b1;
    else if (ovf_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign ovf_flag = flag_q;
  assign ovf_irq  = flag_q & ovf_ie;
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   cfg_mode,
  input logic         cfg_updown,
  input logic         cfg_pause_en,
  input logic         pause_req,
  input logic         ovf_clr,
  input logic         ovf_ie,
  input logic [W-1:0] count,
  input logic         ovf_flag,
  input logic         ovf_irq
);
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 || cfg_mode == 2'b11) |=> $stable(count)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_updown) && count != $past(count)) |->
      (count == W'($past(count) + 1'b1) || count == '0)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0)); // R4

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && cfg_pause_en) |=> $stable(count)); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag || !ovf_ie) |-> !ovf_irq); // R12
endmodule

bind trig_timer trig_timer_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .cfg_updown   (cfg_updown),
  .cfg_pause_en (cfg_pause_en),
  .pause_req    (pause_req),
  .ovf_clr      (ovf_clr),
  .ovf_ie       (ovf_ie),
  .count        (count),
  .ovf_flag     (ovf_flag),
  .ovf_irq      (ovf_irq)
);

// File: tb/sim_trig_timer.sv
module sim_trig_timer;
  localparam int W = 8;
  localparam int PSC_W = 3;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  psc;
    logic        ud;
    logic [7:0]  modv;
    logic [15:0] n;
    logic [7:0]  ecnt;
    logic        eflg;
  } vec_t;

  // mode, prescale, updown, modulo, edges, expected count, expected flag
  localparam vec_t VECS [12] = '{
    '{2'd1, 3'd0, 1'b0, 8'd9,   16'd6,   8'd5, 1'b0},
    '{2'd1, 3'd0, 1'b0, 8'd4,   16'd8,   8'd2, 1'b1},
    '{2'd1, 3'd2, 1'b0, 8'd20,  16'd21,  8'd5, 1'b0},
    '{2'd1, 3'd7, 1'b0, 8'd255, 16'd385, 8'd3, 1'b0},
    '{2'd1, 3'd0, 1'b1, 8'd3,   16'd6,   8'd1, 1'b0},
    '{2'd1, 3'd0, 1'b1, 8'd3,   16'd7,   8'd0, 1'b1},
    '{2'd1, 3'd1, 1'b1, 8'd5,   16'd17,  8'd2, 1'b0},
    '{2'd0, 3'd0, 1'b0, 8'd9,   16'd10,  8'd0, 1'b0},
    '{2'd3, 3'd0, 1'b0, 8'd9,   16'd10,  8'd0, 1'b0},
    '{2'd1, 3'd0, 1'b1, 8'd0,   16'd4,   8'd0, 1'b1},
    '{2'd1, 3'd3, 1'b1, 8'd2,   16'd41,  8'd1, 1'b1},
    '{2'd1, 3'd0, 1'b0, 8'd0,   16'd3,   8'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, ext_clk, trig_in, pause_req;
  logic [1:0]       cfg_mode;
  logic [PSC_W-1:0] cfg_psc;
  logic             cfg_updown, cfg_trig_pol, cfg_start_trig, cfg_stop_ovf;
  logic             cfg_reload_trig, cfg_pause_en, ovf_ie, ovf_clr;
  logic [W-1:0]     cfg_modulo, count;
  logic             ovf_flag, ovf_irq;

  int total = 0;
  int bad   = 0;

  trig_timer #(.W(W), .PSC_W(PSC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .trig_in(trig_in),
    .pause_req(pause_req), .cfg_mode(cfg_mode), .cfg_psc(cfg_psc),
    .cfg_updown(cfg_updown), .cfg_modulo(cfg_modulo),
    .cfg_trig_pol(cfg_trig_pol), .cfg_start_trig(cfg_start_trig),
    .cfg_stop_ovf(cfg_stop_ovf), .cfg_reload_trig(cfg_reload_trig),
    .cfg_pause_en(cfg_pause_en), .ovf_ie(ovf_ie), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_clk = 1'b0; trig_in = 1'b0; pause_req = 1'b0;
    cfg_mode = 2'b00; cfg_psc = '0; cfg_updown = 1'b0; cfg_modulo = '0;
    cfg_trig_pol = 1'b0; cfg_start_trig = 1'b0; cfg_stop_ovf = 1'b0;
    cfg_reload_trig = 1'b0; cfg_pause_en = 1'b0; ovf_ie = 1'b0; ovf_clr = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(3);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [2:0] p,
                         input logic ud, input logic [7:0] mv);
    cfg_mode = m; cfg_psc = p; cfg_updown = ud; cfg_modulo = mv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R13 reset state
    do_reset();
    chk("R13 count", int'(count), 0);
    chk("R13 flag", int'(ovf_flag), 0);
    chk("R13 irq", int'(ovf_irq), 0);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < 12; i++) begin
      do_reset();
      set_cfg(VECS[i].mode, VECS[i].psc, VECS[i].ud, VECS[i].modv);
      edges(int'(VECS[i].n));
      if (VECS[i].mode != 2'd1) begin
        chk($sformatf("R2 vec%0d count", i), int'(count), int'(VECS[i].ecnt));
        chk($sformatf("R2 vec%0d flag", i), int'(ovf_flag), int'(VECS[i].eflg));
      end else if (VECS[i].ud) begin
        chk($sformatf("R4 vec%0d count", i), int'(count), int'(VECS[i].ecnt));
        chk($sformatf("R4 vec%0d flag", i), int'(ovf_flag), int'(VECS[i].eflg));
      end else if (VECS[i].psc != 3'd0) begin
        chk($sformatf("R1 vec%0d count", i), int'(count), int'(VECS[i].ecnt));
        chk($sformatf("R1 vec%0d flag", i), int'(ovf_flag), int'(VECS[i].eflg));
      end else begin
        chk($sformatf("R3 vec%0d count", i), int'(count), int'(VECS[i].ecnt));
        chk($sformatf("R3 vec%0d flag", i), int'(ovf_flag), int'(VECS[i].eflg));
      end
    end

    // R13 asynchronous assertion mid-run
    do_reset();
    set_cfg(2'd1, 3'd0, 1'b0, 8'd50);
    edges(10);
    rst_n = 1'b0;
    #1;
    chk("R13 async count", int'(count), 0);

    // R6 start on trigger
    do_reset();
    cfg_start_trig = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd9);
    edges(6);
    chk("R6 waiting", int'(count), 0);
    trig_in = 1'b1; edges(1); trig_in = 1'b0;
    edges(3);
    chk("R6 started", int'(count), 3);

    // R7 stop on overflow, no trigger start
    do_reset();
    cfg_stop_ovf = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd2);
    edges(10);
    chk("R7 halted count", int'(count), 0);
    chk("R7 halted flag", int'(ovf_flag), 1);

    // R7 re-arm with start on trigger
    do_reset();
    cfg_stop_ovf = 1'b1; cfg_start_trig = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd2);
    edges(2);
    trig_in = 1'b1; edges(1); trig_in = 1'b0;
    edges(3);
    edges(5);
    chk("R7 rearmed idle", int'(count), 0);
    trig_in = 1'b1; edges(1); trig_in = 1'b0;
    edges(2);
    chk("R7 restarted", int'(count), 2);

    // R8 reload, up-only
    do_reset();
    cfg_reload_trig = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd200);
    edges(20);
    trig_in = 1'b1; edges(1);
    chk("R8 reload", int'(count), 0);
    trig_in = 1'b0; edges(3);
    chk("R8 after reload", int'(count), 3);

    // R8 reload in up-down while falling forces direction up
    do_reset();
    cfg_reload_trig = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b1, 8'd5);
    edges(9);
    chk("R8 ud before", int'(count), 2);
    trig_in = 1'b1; edges(1); trig_in = 1'b0;
    edges(2);
    chk("R8 ud climbs", int'(count), 2);

    // R9 active-low trigger
    do_reset();
    cfg_reload_trig = 1'b1; cfg_trig_pol = 1'b1; trig_in = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd200);
    edges(10);
    trig_in = 1'b0; edges(1);
    chk("R9 falling reloads", int'(count), 0);
    trig_in = 1'b1; edges(4);
    chk("R9 rising ignored", int'(count), 4);

    // R10 pause holds and masks trigger
    do_reset();
    cfg_reload_trig = 1'b1; cfg_pause_en = 1'b1;
    set_cfg(2'd1, 3'd0, 1'b0, 8'd200);
    edges(6);
    pause_req = 1'b1; edges(2);
    trig_in = 1'b1; edges(1); trig_in = 1'b0;
    edges(2);
    chk("R10 paused", int'(count), 5);
    pause_req = 1'b0; edges(3);
    chk("R10 resumed", int'(count), 8);
    cfg_pause_en = 1'b0; pause_req = 1'b1; edges(2);
    chk("R10 pause disabled", int'(count), 10);
    pause_req = 1'b0;

    // R11 set and clear in the same cycle, R12 interrupt gating
    do_reset();
    set_cfg(2'd1, 3'd0, 1'b0, 8'd2);
    edges(3);
    chk("R11 pre wrap", int'(ovf_flag), 0);
    ovf_clr = 1'b1; edges(1); ovf_clr = 1'b0;
    chk("R11 set wins", int'(ovf_flag), 1);
    chk("R11 wrap count", int'(count), 0);
    chk("R12 irq masked", int'(ovf_irq), 0);
    ovf_ie = 1'b1; #1;
    chk("R12 irq enabled", int'(ovf_irq), 1);
    @(negedge clk);
    ovf_clr = 1'b1; edges(1); ovf_clr = 1'b0;
    chk("R11 cleared", int'(ovf_flag), 0);
    chk("R12 irq cleared", int'(ovf_irq), 0);
    edges(2);
    chk("R11 set again", int'(ovf_flag), 1);

    // R5 external clock latency
    do_reset();
    set_cfg(2'd2, 3'd0, 1'b0, 8'd50);
    edges(3);
    ext_clk = 1'b1; edges(2);
    chk("R5 sync latency", int'(count), 0);
    edges(1);
    chk("R5 third edge", int'(count), 1);

    // R5 external pulses
    do_reset();
    set_cfg(2'd2, 3'd0, 1'b0, 8'd50);
    edges(3);
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; edges(3);
      ext_clk = 1'b0; edges(3);
    end
    edges(4);
    chk("R5 ext count", int'(count), 5);

    // R1 R5 prescaled external clock
    do_reset();
    set_cfg(2'd2, 3'd1, 1'b0, 8'd50);
    edges(3);
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1'b1; edges(3);
      ext_clk = 1'b0; edges(3);
    end
    edges(4);
    chk("R1 R5 ext prescaled", int'(count), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule